// File: doc/BRIEF.md
# Global Counter with Compare Timer

This block is a free-running up-counter with a single comparator, controlled through a small register interface of simple write strobes and a combinational read port. Software can load the counter one 32-bit half at a time, start or stop it, and program a compare value. When the comparator is enabled and the counter equals the compare value across its full width, a sticky status bit is raised. That status bit, gated by an enable bit, drives the interrupt line.

For periodic interrupts, software programs a step value and turns on auto-advance. After each match the comparator then adds the step to its compare value, so matches repeat at a fixed spacing without software action. Every write to the compare halves, the step or the control register is confirmed by a sticky acknowledge bit. Writes to the counter halves are confirmed the same way, in a separate register. Software clears these bits by writing ones to them.

Top module: `gcmp_timer`

## Requirements
- R1: After reset the counter, compare value, step, control, status, interrupt enable and both acknowledge registers read zero, and `irq` is low.
- R2: While control bit 0 (run) is set, the counter grows by one per clock and wraps to zero past its maximum; the carry passes from the low half into the upper half. While run is clear, the counter holds its value.
- R3: A write to counter low (0x00) or counter high (0x04) replaces that half and keeps the other half. The counter does not advance in that cycle.
- R4: While control bit 1 (compare enable) is set and the counter equals the compare value on all bits, the interrupt status bit (0x24 bit 0) is set on the next clock. The compare value sits at 0x10 (low) and 0x14 (high). A difference in the upper half alone prevents a match.
- R5: The status bit stays set until a write of 1 to 0x24 bit 0. If a match arrives in the same cycle as the clear, the status stays set.
- R6: `irq` is high exactly when the status bit and the interrupt enable (0x28 bit 0) are both set.
- R7: When control bit 2 (auto-advance) is set, each match adds the step (0x18, zero-extended) to the compare value, so matches recur every step counts.
- R8: A write to compare low, compare high, step or control sets bit 0, 1, 2 or 3 of the acknowledge register (0x2C) on the second clock edge after the write strobe is sampled.
- R9: A write to counter low or counter high sets bit 0 or 1 of the counter acknowledge register (0x08) with the same timing as R8.
- R10: Writing 1 to an acknowledge bit clears it. If a set arrives in the same cycle as the clear, the bit stays set.
- R11: Each register reads back what was written, limited to its width: control keeps 3 bits, the interrupt enable keeps 1 bit, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Compare interrupt |

## Verification
The bench uses the default parameters: a 64-bit counter (CNT_W = 64) and an 8-bit address (ADDR_W = 8). At this width a wrap or a carry cannot be reached by counting from reset, so the bench writes the counter halves to values just below the 32-bit and 64-bit boundaries. This exercises the carry between halves and the full wrap within a few cycles. The compare tests use a stopped counter placed equal to the compare value. This makes a match present in every cycle and brings the case where a match and a status clear collide within reach. It also covers a compare value that matches only in its low half.

// File: rtl/gcmp_timer.sv
`timescale 1ns/10ps
module gcmp_timer #(
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int HI_W = CNT_W - 32;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_CNT_HI  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_CNT_ACK = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_CMP_LO  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CMP_HI  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_STEP    = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_IRQ_ST  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] A_IRQ_EN  = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] A_ACK     = ADDR_W'('h2C);
  localparam logic [CNT_W-1:0]  ONE       = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt, cmp;
  logic [31:0]      step;
  logic [2:0]       ctrl;
  logic             irq_st, irq_en;
  logic [3:0]       ack_q, pend;
  logic [1:0]       cnt_ack, cnt_pend;

  wire w_cnt_lo  = wr_en && addr == A_CNT_LO;
  wire w_cnt_hi  = wr_en && addr == A_CNT_HI;
  wire w_cnt_ack = wr_en && addr == A_CNT_ACK;
  wire w_cmp_lo  = wr_en && addr == A_CMP_LO;
  wire w_cmp_hi  = wr_en && addr == A_CMP_HI;
  wire w_step    = wr_en && addr == A_STEP;
  wire w_ctrl    = wr_en && addr == A_CTRL;
  wire w_irq_st  = wr_en && addr == A_IRQ_ST;
  wire w_irq_en  = wr_en && addr == A_IRQ_EN;
  wire w_ack     = wr_en && addr == A_ACK;

  wire              run      = ctrl[0];
  wire              cmp_on   = ctrl[1];
  wire              auto_adv = ctrl[2];
  wire              match    = cmp_on && (cnt == cmp);
  wire [CNT_W-1:0]  step_ext = {{HI_W{1'b0}}, step};

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (w_cnt_lo || w_cnt_hi) begin
      if (w_cnt_lo) cnt[31:0]      <= wdata;
      if (w_cnt_hi) cnt[CNT_W-1:32] <= wdata[HI_W-1:0];
    end else if (run) cnt <= cnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmp <= '0;
    else if (w_cmp_lo || w_cmp_hi) begin
      if (w_cmp_lo) cmp[31:0]       <= wdata;
      if (w_cmp_hi) cmp[CNT_W-1:32] <= wdata[HI_W-1:0];
    end else if (match && auto_adv) cmp <= cmp + step_ext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step   <= '0;
      ctrl   <= '0;
      irq_en <= 1'b0;
      irq_st <= 1'b0;
    end else begin
      if (w_step)   step   <= wdata;
      if (w_ctrl)   ctrl   <= wdata[2:0];
      if (w_irq_en) irq_en <= wdata[0];
      irq_st <= match | (irq_st & ~(w_irq_st & wdata[0]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      cnt_pend <= '0;
      ack_q    <= '0;
      cnt_ack  <= '0;
    end else begin
      pend     <= {w_ctrl, w_step, w_cmp_hi, w_cmp_lo};
      cnt_pend <= {w_cnt_hi, w_cnt_lo};
      ack_q    <= pend | (ack_q & ~(w_ack ? wdata[3:0] : 4'b0));
      cnt_ack  <= cnt_pend | (cnt_ack & ~(w_cnt_ack ? wdata[1:0] : 2'b0));
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CNT_LO:  rdata = cnt[31:0];
      A_CNT_HI:  rdata = 32'(cnt[CNT_W-1:32]);
      A_CNT_ACK: rdata = {30'b0, cnt_ack};
      A_CMP_LO:  rdata = cmp[31:0];
      A_CMP_HI:  rdata = 32'(cmp[CNT_W-1:32]);
      A_STEP:    rdata = step;
      A_CTRL:    rdata = {29'b0, ctrl};
      A_IRQ_ST:  rdata = {31'b0, irq_st};
      A_IRQ_EN:  rdata = {31'b0, irq_en};
      A_ACK:     rdata = {28'b0, ack_q};
      default:   rdata = '0;
    endcase
  end

  assign irq = irq_st & irq_en;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && !w_cnt_lo && !w_cnt_hi |=> cnt == $past(cnt) + ONE);
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !w_cnt_lo && !w_cnt_hi |=> $stable(cnt));
  p_match_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> irq_st);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_st && !(w_irq_st && wdata[0]) |=> irq_st);
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en && irq_st);
  p_auto_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match && auto_adv && !w_cmp_lo && !w_cmp_hi |=> cmp == $past(cmp) + $past(step_ext));
  p_ack_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    w_ctrl |-> ##2 ack_q[3]);
  p_cnt_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    w_cnt_lo |-> ##2 cnt_ack[0]);
endmodule

// File: tb/test_gcmp_timer.sv
`timescale 1ns/10ps
module test_gcmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;

  gcmp_timer #(.CNT_W(64), .ADDR_W(8)) i_gcmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  localparam logic [7:0] CLO = 8'h00, CHI = 8'h04, CACK = 8'h08, MLO = 8'h10,
    MHI = 8'h14, STP = 8'h18, CTL = 8'h20, IST = 8'h24, IEN = 8'h28, ACK = 8'h2C;

  localparam logic [71:0] VEC [8] = '{
    {8'h10, 32'hDEADBEEF, 32'hDEADBEEF},
    {8'h14, 32'h12345678, 32'h12345678},
    {8'h18, 32'h00000040, 32'h00000040},
    {8'h28, 32'hFFFFFFFF, 32'h00000001},
    {8'h20, 32'hFFFFFFFF, 32'h00000007},
    {8'h20, 32'h00000000, 32'h00000000},
    {8'h28, 32'h00000000, 32'h00000000},
    {8'h3C, 32'hFFFFFFFF, 32'h00000000}};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; #0.2; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    foreach (VEC[i]) begin rd(VEC[i][71:64], v); chk("R1 reset read", v, 32'h0); end
    rd(CLO, v); chk("R1 counter low", v, 0);
    rd(ACK, v); chk("R1 ack", v, 0);
    rd(CACK, v); chk("R1 counter ack", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R11 readback table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk("R11 readback", v, VEC[i][31:0]);
    end
    idle(2);
    wr(ACK, 32'hF);
    rd(ACK, v); chk("R10 ack cleared", v, 0);

    // R8 timing and R10 set-wins
    wr(MLO, 32'h1);
    rd(ACK, v); chk("R8 ack not yet", v, 0);
    idle(1);
    rd(ACK, v); chk("R8 ack set", v, 32'h1);
    wr(MHI, 32'h0);
    wr(ACK, 32'h2);
    rd(ACK, v); chk("R10 set wins over clear", v, 32'h3);
    wr(ACK, 32'h2);
    rd(ACK, v); chk("R10 clear one bit", v, 32'h1);

    // R9 counter acks
    wr(CLO, 32'hFFFFFFFE);
    wr(CHI, 32'h5);
    idle(1);
    rd(CACK, v); chk("R9 counter ack", v, 32'h3);
    wr(CACK, 32'h3);
    rd(CACK, v); chk("R9 counter ack clear", v, 0);

    // R2 counting with carry
    wr(CTL, 32'h1);
    idle(3);
    rd(CLO, v); chk("R2 carry low", v, 32'h1);
    rd(CHI, v); chk("R2 carry high", v, 32'h6);
    wr(CTL, 32'h0);
    rd(CLO, v);
    idle(5);
    rd(CLO, v2); chk("R2 halt", v2, v);
    // R3 half write keeps other half
    wr(CHI, 32'h77);
    rd(CLO, v2); chk("R3 low kept", v2, v);
    rd(CHI, v2); chk("R3 high written", v2, 32'h77);
    // R2 full wrap
    wr(CLO, 32'hFFFFFFFF);
    wr(CHI, 32'hFFFFFFFF);
    wr(CTL, 32'h1);
    idle(2);
    rd(CLO, v); chk("R2 wrap low", v, 32'h1);
    rd(CHI, v); chk("R2 wrap high", v, 32'h0);
    wr(CTL, 32'h0);

    // R4 upper half mismatch
    wr(CLO, 32'd100); wr(CHI, 0);
    wr(MLO, 32'd100); wr(MHI, 32'h1);
    wr(IEN, 32'h1);
    wr(CTL, 32'h2);
    idle(3);
    rd(IST, v); chk("R4 no match on high diff", v, 0);
    // R4 match after counting
    wr(CTL, 32'h0);
    wr(MLO, 32'd110); wr(MHI, 0);
    wr(CTL, 32'h3);
    idle(9);
    rd(IST, v); chk("R4 before match", v, 0);
    chk("R6 irq low before", {31'b0, irq}, 0);
    idle(3);
    rd(IST, v); chk("R4 match sets status", v, 32'h1);
    chk("R6 irq high", {31'b0, irq}, 1);
    wr(IEN, 32'h0);
    chk("R6 irq gated off", {31'b0, irq}, 0);
    rd(IST, v); chk("R5 status held", v, 32'h1);
    wr(IST, 32'h1);
    rd(IST, v); chk("R5 status cleared", v, 0);
    wr(IEN, 32'h1);

    // R5 set wins over clear
    wr(CTL, 32'h0);
    wr(CLO, 32'd50); wr(CHI, 0);
    wr(MLO, 32'd50);
    wr(CTL, 32'h2);
    idle(2);
    wr(IST, 32'h1);
    rd(IST, v); chk("R5 set wins", v, 32'h1);
    wr(CTL, 32'h0);
    wr(IST, 32'h1);
    rd(IST, v); chk("R5 clear after stop", v, 0);

    // R7 auto-advance
    wr(CLO, 0);
    wr(MLO, 32'd5);
    wr(STP, 32'd8);
    wr(CTL, 32'h7);
    idle(25);
    rd(CLO, v); chk("R7 counter position", v, 32'd25);
    rd(MLO, v); chk("R7 compare advanced", v, 32'd29);
    rd(IST, v); chk("R7 status from match", v, 32'h1);
    wr(CTL, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule